// File: doc/BRIEF.md
# Serial MII MAC Link

This block sits at the MAC end of a low-pin-count serial MII connection. Both ends share one reference clock. The block drives a sync strobe, one transmit line and one receive line. Traffic moves in 10-bit segments, and the strobe is high during the first bit slot of each segment.

On the transmit side, the block takes a byte, and an error flag with it, from a valid/ready port. It sends the byte as a segment with an error bit, an enable bit and the data bits. On the receive side, it reassembles each segment. A segment whose second bit is set delivers a data byte to the MAC. A segment with that bit clear carries a packed PHY status word, and the block latches that word into status outputs.

The mode input selects 100 Mb/s operation or 10 Mb/s operation. At 100 Mb/s a new segment starts every 10 clocks. At 10 Mb/s each segment is repeated ten times, one group per 100 clocks.

Top module: `serial_mii_mac`

## Requirements
- R1: While `rst` is high, `sync_o`, `txd_o`, `tx_ready_o`, `rx_valid_o`, `rx_crs_o` and all five status outputs are 0.
- R2: The first `sync_o` pulse is on the first clock after `rst` falls. After that, `sync_o` is high for exactly one clock in every 10 (the bit slot 0 of each segment).
- R3: A transmitted segment puts the error flag on `txd_o` in slot 0 (the sync cycle) and a 1 for enable in slot 1. The data byte follows in slots 2 to 9, least significant bit first.
- R4: If no byte is accepted at a group start, every slot of the segment is 0. `tx_err_i` then has no effect on `txd_o`.
- R5: `tx_ready_o` is high only in the last clock of a segment group, which is the clock before a sync pulse. A byte is taken at that edge when `tx_valid_i` is high. At 100 Mb/s this happens once every 10 clocks, and at 10 Mb/s once every 100 clocks.
- R6: At 10 Mb/s, the segment built from one byte appears on `txd_o` ten times in a row, with the same bits each time.
- R7: On `rxd_i`, slot 0 carries carrier sense and slot 1 carries data-valid. When data-valid is 1, slots 2 to 9 carry a byte, LSB first. `rx_valid_o` is then high for exactly one clock, the sync cycle after slot 9, with the byte on `rx_data_o`. `rx_crs_o` takes slot 0 of each decoded segment.
- R8: When data-valid is 0, slots 2 to 6 hold, in order: receive error, speed (1 means 100 Mb/s), duplex, link and jabber. These values are loaded into the status outputs with no `rx_valid_o` pulse. The outputs hold until the next status segment, and data segments leave them unchanged.
- R9: At 10 Mb/s, only the first copy of each group of ten is decoded. The other nine copies have no effect on any receive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared reference clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_fast | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s with tenfold repeat |
| sync_o | output | 1 | Segment strobe, high in slot 0 |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |
| tx_valid_i | input | 1 | MAC offers a byte |
| tx_data_i | input | 8 | Byte to send |
| tx_err_i | input | 1 | Error flag sent with the byte |
| tx_ready_o | output | 1 | Byte is taken at this clock edge if valid |
| rx_valid_o | output | 1 | One-clock pulse with a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_crs_o | output | 1 | Carrier sense from the last decoded segment |
| phy_rx_err_o | output | 1 | Latched receive error status |
| phy_speed_o | output | 1 | Latched speed status |
| phy_duplex_o | output | 1 | Latched duplex status |
| phy_link_o | output | 1 | Latched link status |
| phy_jabber_o | output | 1 | Latched jabber status |

## Verification
The bench builds the block with its defaults: an 8-bit byte, which makes a 10-bit segment, and a repeat count of 10. Because of this, a whole 10 Mb/s group of 100 clocks fits easily into a directed test. All ten copies on the transmit line are compared bit by bit. On the receive side, the nine later copies are driven with contents that contradict the first copy, so any decode of them shows up at the ports. At 100 Mb/s, the same scenarios are run back to back, segment after segment, to cover the boundaries between adjacent segments.

// File: rtl/serial_mii_pkg.sv
package serial_mii_pkg;

  // Latched PHY status; packed so that rx_err is the lowest bit.
  typedef struct packed {
    logic jabber;
    logic link;
    logic duplex;
    logic speed;
    logic rx_err;
  } phy_stat_t;

  localparam int unsigned STAT_W  = 5;

  // Slot positions within a segment
  localparam int unsigned POS_FLAG  = 0; // tx error / rx carrier sense
  localparam int unsigned POS_VALID = 1; // tx enable / rx data valid
  localparam int unsigned POS_PAY   = 2; // first payload slot

endpackage

// File: rtl/smii_seg_timer.sv
module smii_seg_timer #(
  parameter int SEG_LEN = 10,
  parameter int REPEAT  = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fast,
  output logic [$clog2(SEG_LEN)-1:0] slot_o,
  output logic                       seg_last_o,
  output logic                       grp_last_o,
  output logic                       grp_first_o,
  output logic                       sync_o
);
  localparam int SLOT_W = $clog2(SEG_LEN);
  localparam int REP_W  = (REPEAT > 1) ? $clog2(REPEAT) : 1;
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SEG_LEN - 1);
  localparam logic [REP_W-1:0]  REP_END  = REP_W'(REPEAT - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [REP_W-1:0]  rep_q;
  logic              sync_q;

  assign seg_last_o  = (slot_q == SLOT_END);
  assign grp_last_o  = seg_last_o & (fast | (rep_q == REP_END));
  assign grp_first_o = fast | (rep_q == '0);
  assign slot_o      = slot_q;
  assign sync_o      = sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= SLOT_END;
      rep_q  <= REP_END;
      sync_q <= 1'b0;
    end else begin
      slot_q <= seg_last_o ? '0 : slot_q + 1'b1;
      sync_q <= seg_last_o;
      if (fast)
        rep_q <= '0;
      else if (seg_last_o)
        rep_q <= (rep_q == REP_END) ? '0 : rep_q + 1'b1;
    end
  end

  // R2: the strobe never lasts two clocks
  a_r2_sync_single: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> !sync_o);

  // R6: the repeat index moves only across a segment boundary
  a_r6_rep_steady: assert property (@(posedge clk) disable iff (rst)
    (!seg_last_o && !fast) |=> $stable(rep_q));

endmodule

// File: rtl/smii_tx_ser.sv
module smii_tx_ser #(
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load,
  input  logic                              seg_last,
  input  logic [$clog2(DATA_W + 2)-1:0]     slot,
  input  logic                              byte_valid,
  input  logic [DATA_W-1:0]                 byte_data,
  input  logic                              byte_err,
  output logic                              byte_ready,
  output logic                              line_o
);
  import serial_mii_pkg::*;

  localparam int SEG_LEN = DATA_W + 2;
  localparam int SLOT_W  = $clog2(SEG_LEN);

  logic [SEG_LEN-1:0] frm_q;
  logic [SEG_LEN-1:0] frm_new;
  logic [SLOT_W-1:0]  slot_nxt;
  logic               nxt_bit;
  logic               take;
  logic               line_q;

  assign byte_ready = load & ~rst;
  assign take       = load & byte_valid;
  assign slot_nxt   = slot + 1'b1;
  assign line_o     = line_q;

  always_comb begin
    frm_new = '0;
    if (take) begin
      frm_new[POS_FLAG]            = byte_err;
      frm_new[POS_VALID]           = 1'b1;
      frm_new[POS_PAY +: DATA_W]   = byte_data;
    end
  end

  always_comb begin
    nxt_bit = 1'b0;
    for (int i = 0; i < SEG_LEN; i++)
      if (slot_nxt == SLOT_W'(i))
        nxt_bit = frm_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q  <= '0;
      line_q <= 1'b0;
    end else if (load) begin
      frm_q  <= frm_new;
      line_q <= frm_new[POS_FLAG];
    end else if (seg_last) begin
      line_q <= frm_q[POS_FLAG];
    end else begin
      line_q <= nxt_bit;
    end
  end

  // R3: an accepted byte shows its error flag, then enable high
  a_r3_flag_then_enable: assert property (@(posedge clk) disable iff (rst)
    take |=> (line_o == $past(byte_err)) ##1 line_o);

  // R4: an idle group start sends zeros in the two control slots
  a_r4_idle_control: assert property (@(posedge clk) disable iff (rst)
    (load && !byte_valid) |=> !line_o ##1 !line_o);

  // R6: the segment content is held across all repeats of a group
  a_r6_frame_held: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(frm_q));

endmodule

// File: rtl/smii_rx_des.sv
module smii_rx_des #(
  parameter int DATA_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(DATA_W + 2)-1:0]     slot,
  input  logic                              seg_last,
  input  logic                              grp_first,
  input  logic                              line_i,
  output logic                              valid_o,
  output logic [DATA_W-1:0]                 data_o,
  output logic                              crs_o,
  output serial_mii_pkg::phy_stat_t         stat_o
);
  import serial_mii_pkg::*;

  localparam int SEG_LEN = DATA_W + 2;
  localparam int SLOT_W  = $clog2(SEG_LEN);

  logic [SEG_LEN-2:0] sh_q;
  logic [SEG_LEN-1:0] seg;
  logic               armed_q;
  logic               decode;
  logic               valid_q;
  logic [DATA_W-1:0]  data_q;
  logic               crs_q;
  phy_stat_t          stat_q;

  assign seg     = {line_i, sh_q};
  assign decode  = seg_last & grp_first & armed_q;
  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign crs_o   = crs_q;
  assign stat_o  = stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      for (int i = 0; i < SEG_LEN - 1; i++)
        if (slot == SLOT_W'(i))
          sh_q[i] <= line_i;
      if (slot == '0)
        armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      crs_q   <= 1'b0;
      stat_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (decode) begin
        crs_q <= seg[POS_FLAG];
        if (seg[POS_VALID]) begin
          valid_q <= 1'b1;
          data_q  <= seg[POS_PAY +: DATA_W];
        end else begin
          stat_q  <= seg[POS_PAY +: STAT_W];
        end
      end
    end
  end

  // R7: a received byte is flagged for exactly one clock
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R8: a data segment leaves the status word alone
  a_r8_status_kept: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $stable(stat_q));

  // R9: carrier sense moves only on a decoded copy
  a_r9_crs_quiet: assert property (@(posedge clk) disable iff (rst)
    !decode |=> $stable(crs_q));

endmodule

// File: rtl/serial_mii_mac.sv
module serial_mii_mac #(
  parameter int DATA_W = 8,
  parameter int REPEAT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_fast,
  output logic              sync_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_err_i,
  output logic              tx_ready_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_crs_o,
  output logic              phy_rx_err_o,
  output logic              phy_speed_o,
  output logic              phy_duplex_o,
  output logic              phy_link_o,
  output logic              phy_jabber_o
);
  import serial_mii_pkg::*;

  localparam int SEG_LEN = DATA_W + 2;
  localparam int SLOT_W  = $clog2(SEG_LEN);

  logic [SLOT_W-1:0] slot;
  logic              seg_last;
  logic              grp_last;
  logic              grp_first;
  phy_stat_t         stat;

  smii_seg_timer #(.SEG_LEN(SEG_LEN), .REPEAT(REPEAT)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .fast       (mode_fast),
    .slot_o     (slot),
    .seg_last_o (seg_last),
    .grp_last_o (grp_last),
    .grp_first_o(grp_first),
    .sync_o     (sync_o)
  );

  smii_tx_ser #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load      (grp_last),
    .seg_last  (seg_last),
    .slot      (slot),
    .byte_valid(tx_valid_i),
    .byte_data (tx_data_i),
    .byte_err  (tx_err_i),
    .byte_ready(tx_ready_o),
    .line_o    (txd_o)
  );

  smii_rx_des #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .slot     (slot),
    .seg_last (seg_last),
    .grp_first(grp_first),
    .line_i   (rxd_i),
    .valid_o  (rx_valid_o),
    .data_o   (rx_data_o),
    .crs_o    (rx_crs_o),
    .stat_o   (stat)
  );

  assign phy_rx_err_o = stat.rx_err;
  assign phy_speed_o  = stat.speed;
  assign phy_duplex_o = stat.duplex;
  assign phy_link_o   = stat.link;
  assign phy_jabber_o = stat.jabber;

  // R5: a hand-off edge is always followed by a segment start
  a_r5_ready_then_sync: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |=> sync_o);

  // R7: received bytes appear only in the sync cycle
  a_r7_valid_on_sync: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> sync_o);

endmodule

// File: tb/serial_mii_mac_tb_top.sv
`timescale 1ns/1ps
module serial_mii_mac_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_fast = 1'b1;
  logic       rxd = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_err = 1'b0;
  logic       sync_o, txd_o, tx_ready, rx_valid, rx_crs;
  logic [7:0] rx_data;
  logic       st_er, st_spd, st_dup, st_lnk, st_jab;

  int nchk = 0;
  int nfail = 0;
  int cyc;
  int G = 10;
  logic [9:0] idle_seg;
  logic [4:0] cur_st;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  serial_mii_mac dut_i (
    .clk(clk), .rst(rst), .mode_fast(mode_fast),
    .sync_o(sync_o), .txd_o(txd_o), .rxd_i(rxd),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_err_i(tx_err),
    .tx_ready_o(tx_ready),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data), .rx_crs_o(rx_crs),
    .phy_rx_err_o(st_er), .phy_speed_o(st_spd), .phy_duplex_o(st_dup),
    .phy_link_o(st_lnk), .phy_jabber_o(st_jab)
  );

  function automatic logic [9:0] mk_status(bit crs, bit er, bit spd, bit dup, bit lnk, bit jab);
    return {1'b1, 1'b0, 1'b1, jab, lnk, dup, spd, er, 1'b0, crs};
  endfunction

  function automatic logic [9:0] mk_data(bit crs, logic [7:0] d);
    return {d, 1'b1, crs};
  endfunction

  function automatic int slot_of(int c);
    return (c == 0) ? 9 : (c - 1) % 10;
  endfunction

  function automatic logic [4:0] stat_now();
    return {st_jab, st_lnk, st_dup, st_spd, st_er};
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    rxd = idle_seg[slot_of(cyc)];
  endtask

  task automatic align();
    while (cyc % G != 0) step();
  endtask

  task automatic do_reset(bit f);
    @(negedge clk);
    rst = 1'b1;
    mode_fast = f;
    G = f ? 10 : 100;
    tx_valid = 1'b0;
    tx_err = 1'b0;
    rxd = 1'b0;
    idle_seg = mk_status(0, 0, 0, 0, 0, 0);
    cur_st = '0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs while reset is held
    chk(sync_o == 1'b0, "R1", "sync in reset", int'(sync_o), 0);
    chk(txd_o == 1'b0, "R1", "txd in reset", int'(txd_o), 0);
    chk(tx_ready == 1'b0, "R1", "ready in reset", int'(tx_ready), 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
    chk(rx_crs == 1'b0, "R1", "crs in reset", int'(rx_crs), 0);
    chk(stat_now() == 5'd0, "R1", "status in reset", int'(stat_now()), 0);
    rst = 1'b0;
  endtask

  task automatic t_sync(int n);
    for (int i = 0; i < n; i++) begin
      step();
      // R2: strobe on slot 0 only, first one right after reset
      chk(sync_o == (slot_of(cyc) == 0), "R2", "sync cadence",
          int'(sync_o), int'(slot_of(cyc) == 0));
    end
  endtask

  task automatic tx_seg(bit v, logic [7:0] d, bit e);
    logic [9:0] frm;
    int reps;
    int bad0, badn, badr;
    align();
    reps = mode_fast ? 1 : 10;
    frm = v ? {d, 1'b1, e} : 10'd0;
    bad0 = 0; badn = 0; badr = 0;
    chk(tx_ready == 1'b1, "R5", "ready at group end", int'(tx_ready), 1);
    tx_valid = v;
    tx_data = d;
    tx_err = e;
    for (int c = 0; c < reps; c++) begin
      for (int s = 0; s < 10; s++) begin
        step();
        if (c == 0 && s == 0) begin
          tx_valid = 1'b0;
          tx_err = 1'b0;
        end
        if (txd_o !== frm[s]) begin
          if (c == 0) bad0++;
          else badn++;
        end
        if (tx_ready !== (s == 9 && c == reps - 1)) badr++;
      end
    end
    if (v) chk(bad0 == 0, "R3", "segment bits", bad0, 0);
    else   chk(bad0 == 0, "R4", "idle segment bits", bad0, 0);
    if (!mode_fast) chk(badn == 0, "R6", "repeated copies", badn, 0);
    chk(badr == 0, "R5", "ready timing", badr, 0);
  endtask

  task automatic check_dec(logic [9:0] seg, string tag);
    logic [4:0] exp_st;
    chk(rx_valid == seg[1], (seg[1] ? "R7" : "R8"), "rx_valid at decode",
        int'(rx_valid), int'(seg[1]));
    if (seg[1])
      chk(rx_data == seg[9:2], "R7", "rx_data", int'(rx_data), int'(seg[9:2]));
    chk(rx_crs == seg[0], "R7", "carrier sense", int'(rx_crs), int'(seg[0]));
    exp_st = seg[1] ? cur_st : seg[6:2];
    chk(stat_now() == exp_st, "R8", "status at decode", int'(stat_now()), int'(exp_st));
    cur_st = exp_st;
    if (tag.len() == 0) cur_st = exp_st;
  endtask

  task automatic rx_seg(logic [9:0] seg, logic [9:0] alt, string tag);
    int reps;
    int pulses;
    align();
    reps = mode_fast ? 1 : 10;
    pulses = 0;
    for (int c = 0; c < reps; c++) begin
      for (int s = 0; s < 10; s++) begin
        step();
        rxd = (c == 0) ? seg[s] : alt[s];
        if (rx_valid) pulses++;
        if (c == 1 && s == 0) check_dec(seg, tag);
      end
    end
    if (mode_fast) begin
      step();
      if (rx_valid) pulses++;
      check_dec(seg, tag);
    end
    chk(pulses == int'(seg[1]), tag, "rx_valid pulse count", pulses, int'(seg[1]));
    chk(stat_now() == cur_st, tag, "status after group", int'(stat_now()), int'(cur_st));
    if (!mode_fast)
      chk(rx_crs == seg[0], "R9", "crs after group", int'(rx_crs), int'(seg[0]));
    idle_seg = {1'b1, 1'b0, 1'b1, cur_st, 1'b0, 1'b0};
  endtask

  task automatic t_reset_and_sync();
    do_reset(1'b1);
    t_sync(30);
  endtask

  task automatic t_tx_fast();
    tx_seg(1'b1, 8'hA5, 1'b0);
    tx_seg(1'b1, 8'h3C, 1'b1);
    tx_seg(1'b0, 8'h00, 1'b0);
    tx_seg(1'b0, 8'hFF, 1'b1);
    tx_seg(1'b1, 8'h81, 1'b0);
  endtask

  task automatic t_rx_fast();
    rx_seg(mk_data(1, 8'h96), 10'd0, "R7");
    rx_seg(mk_status(1, 1, 1, 1, 0, 1), 10'd0, "R8");
    rx_seg(mk_data(0, 8'h5A), 10'd0, "R8");
    rx_seg(mk_status(0, 0, 0, 0, 1, 0), 10'd0, "R8");
    rx_seg(mk_data(1, 8'hFF), 10'd0, "R7");
  endtask

  task automatic t_slow();
    do_reset(1'b0);
    t_sync(20);
    tx_seg(1'b1, 8'h5A, 1'b1);
    tx_seg(1'b0, 8'h00, 1'b1);
    tx_seg(1'b1, 8'hC7, 1'b0);
    rx_seg(mk_data(1, 8'hC3), mk_status(0, 1, 1, 1, 1, 1), "R9");
    rx_seg(mk_status(0, 1, 0, 1, 1, 0), mk_data(1, 8'hFF), "R9");
    rx_seg(mk_status(1, 0, 1, 0, 0, 1), mk_status(0, 1, 0, 1, 1, 0), "R9");
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    idle_seg = mk_status(0, 0, 0, 0, 0, 0);
    cur_st = '0;
    t_reset_and_sync();
    t_tx_fast();
    t_rx_fast();
    t_slow();
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule